// File: doc/BRIEF.md
# Preamble Bit-Timing Recovery

This block turns an oversampled, already-sliced baseband stream into recovered bits. A free-running phase counter spans one nominal bit period (a parameter, default 16 samples). Data edges pull the counter into line with the incoming bit boundaries. At mid-bit the block takes the sampled line level as the recovered bit and pulses a one-cycle strobe with it. Lock is declared once enough consecutive bit periods have each carried a transition. An alternating one/zero preamble is what supplies those transitions.

A two-bit field selects the acquisition mode. In fast mode a data edge resets the phase outright, and a short run of preamble bits gives lock. In slow mode each edge moves the phase by a single sample, and a longer run is needed. Automatic mode behaves as fast mode until lock is reached and then tracks as slow mode. Lock is dropped after a long stretch with no transitions. An enable input, held low whenever the analog filter path is in use, stops the block altogether.

Top module: `preamble_bit_sync`

## Requirements
- R1: While reset is asserted, and right after it is released, `locked`, `bit_stb` and `bit_out` are 0. Asserting reset at any time clears `locked` at once.
- R2: `bit_stb` is never high for two cycles in a row. With the line steady for a full bit period, each bit period produces exactly one strobe, and `bit_out` at that strobe equals the line level of that bit.
- R3: With `mode` = 0 (fast), lock is not reported after 7 transition-bearing bit periods. An alternating preamble brings lock within 11 bit periods. Lock can only rise in the cycle that carries a strobe.
- R4: With `mode` = 1 (slow), or with the spare code `mode` = 3 (treated as slow), lock is not reported after 15 transition-bearing bit periods. An alternating preamble brings lock within 30 bit periods, and each edge moves the phase by at most one sample.
- R5: With `mode` = 2 (automatic), lock behaves as in R3. Once locked, phase tracking switches to slow behaviour. A transition arriving 6 samples late then produces a strobe 5 cycles earlier, relative to that transition, than a well-timed one does.
- R6: In fast tracking, every data edge resets the phase. A transition arriving 6 samples late is followed by a strobe at the same delay as a well-timed one.
- R7: A strobe period with no transition restarts the lock count. After 5 preamble bits and 3 steady bits, a further 7 preamble bits do not give lock.
- R8: Once locked, lock stays up through 29 steady bit periods and is gone after 35. The limit is 32 strobes with no transition.
- R9: With `en` low, `locked` is 0 from the next cycle on and no strobes occur, whatever the line does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one cycle per oversample |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Digital path enable; low when the analog filter path is selected |
| mode | input | 2 | Acquisition mode: 0 fast, 1 slow, 2 automatic, 3 slow |
| din | input | 1 | Sliced baseband sample |
| bit_out | output | 1 | Recovered bit, valid with `bit_stb` |
| bit_stb | output | 1 | One-cycle strobe at mid-bit |
| locked | output | 1 | Bit timing acquired |

## Verification
On every cycle the assertions check the following:
- the strobe is a single-cycle pulse;
- the enable and reset clear the outputs;
- lock rises only with a strobe and falls only at a strobe or after the enable drops;
- a fast-tracking edge realigns the phase to one;
- a slow-tracking edge moves it by no more than one sample;
- automatic mode never tracks fast while locked.

Some behaviours can only be shown by the bench's scenarios, because they depend on a whole preamble: how many bits lock takes in each mode and at off-nominal bit periods, the restart after a gap, the idle timeout, data recovery at mid-bit, and the different strobe timing after a late edge in fast and locked-automatic tracking.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [1:0] {
    PBS_FAST     = 2'd0,
    PBS_SLOW     = 2'd1,
    PBS_AUTO     = 2'd2,
    PBS_SLOW_ALT = 2'd3
  } pbs_mode_e;

  // Phase after one sample: free count, full realign, or a one-sample nudge
  function automatic int unsigned pbs_next_phase(input int unsigned ph,
                                                 input int unsigned spb,
                                                 input bit          edge_seen,
                                                 input bit          fast);
    int unsigned nxt;
    if (!edge_seen) begin
      nxt = (ph + 1) % spb;
    end else if (fast) begin
      nxt = 1 % spb;
    end else if (ph == 0) begin
      nxt = 1;
    end else if (ph < spb / 2) begin
      nxt = ph;                 // edge late: hold one sample
    end else begin
      nxt = (ph + 2) % spb;     // edge early: skip one sample
    end
    return nxt;
  endfunction

  function automatic bit pbs_tracks_fast(input logic [1:0] mode,
                                         input logic       locked);
    return (mode == PBS_FAST) || ((mode == PBS_AUTO) && !locked);
  endfunction

  function automatic int unsigned pbs_need_bits(input bit          fast,
                                                input int unsigned fast_n,
                                                input int unsigned slow_n);
    return fast ? fast_n : slow_n;
  endfunction

endpackage

// File: rtl/pbs_edge_sync.sv
module pbs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic smp,
  output logic edge_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[g] <= 1'b0;
        end else if (g == 0) begin
          chain[g] <= din;
        end else begin
          chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign smp    = chain[STAGES-2];
  assign edge_o = en && (chain[STAGES-2] != chain[STAGES-1]);
endmodule

// File: rtl/pbs_phase.sv
module pbs_phase
  import pbs_pkg::*;
#(
  parameter int SPB = 16,
  localparam int PW = $clog2(SPB),
  localparam int HALF = SPB / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          edge_i,
  input  logic          fast_i,
  output logic [PW-1:0] ph,
  output logic          mid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (!en) begin
      ph <= '0;
    end else begin
      ph <= PW'(pbs_next_phase(32'(ph), SPB, edge_i, fast_i));
    end
  end

  assign mid = en && (ph == PW'(HALF));
endmodule

// File: rtl/pbs_lock.sv
module pbs_lock
  import pbs_pkg::*;
#(
  parameter int FAST_N = 8,
  parameter int SLOW_N = 16,
  parameter int IDLE_N = 32,
  localparam int RW = $clog2(SLOW_N + 1),
  localparam int IW = $clog2(IDLE_N + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       edge_i,
  input  logic       mid,
  output logic       locked,
  output logic       trk_fast
);
  logic          seen;
  logic [RW-1:0] run;
  logic [IW-1:0] idle;
  logic          hit;
  int unsigned   need;
  int unsigned   run_inc;
  int unsigned   idle_inc;

  assign trk_fast = pbs_tracks_fast(mode, locked);
  assign need     = pbs_need_bits(trk_fast, FAST_N, SLOW_N);
  assign hit      = seen || edge_i;
  assign run_inc  = 32'(run) + 1;
  assign idle_inc = 32'(idle) + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      run    <= '0;
      idle   <= '0;
      locked <= 1'b0;
    end else if (!en) begin
      seen   <= 1'b0;
      run    <= '0;
      idle   <= '0;
      locked <= 1'b0;
    end else if (mid) begin
      seen <= 1'b0;
      if (hit) begin
        idle <= '0;
        if (run_inc <= SLOW_N) run <= RW'(run_inc);
        if (!locked && run_inc >= need) locked <= 1'b1;
      end else begin
        run <= '0;
        if (locked) begin
          if (idle_inc >= IDLE_N) begin
            locked <= 1'b0;
            idle   <= '0;
          end else begin
            idle <= IW'(idle_inc);
          end
        end
      end
    end else if (edge_i) begin
      seen <= 1'b1;
    end
  end
endmodule

// File: rtl/preamble_bit_sync.sv
module preamble_bit_sync
  import pbs_pkg::*;
#(
  parameter int SPB    = 16,
  parameter int FAST_N = 8,
  parameter int SLOW_N = 16,
  parameter int IDLE_N = 32,
  parameter int SYNC   = 2,
  localparam int PW = $clog2(SPB)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       din,
  output logic       bit_out,
  output logic       bit_stb,
  output logic       locked
);
  logic          smp_w;
  logic          edge_w;
  logic          mid_w;
  logic          trk_fast_w;
  logic [PW-1:0] ph_w;

  pbs_edge_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din),
    .smp(smp_w), .edge_o(edge_w)
  );

  pbs_phase #(.SPB(SPB)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en), .edge_i(edge_w),
    .fast_i(trk_fast_w), .ph(ph_w), .mid(mid_w)
  );

  pbs_lock #(.FAST_N(FAST_N), .SLOW_N(SLOW_N), .IDLE_N(IDLE_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .edge_i(edge_w),
    .mid(mid_w), .locked(locked), .trk_fast(trk_fast_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out <= 1'b0;
      bit_stb <= 1'b0;
    end else begin
      bit_stb <= mid_w;
      if (mid_w) bit_out <= smp_w;
    end
  end
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
  parameter int SPB = 16,
  localparam int PW = $clog2(SPB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [1:0]    mode,
  input logic          bit_stb,
  input logic          locked,
  input logic          edge_i,
  input logic          trk_fast,
  input logic [PW-1:0] ph
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!locked && !bit_stb));

  p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  p_lock_with_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> bit_stb);

  p_slow_nudge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edge_i && !trk_fast) |=>
      ((32'(ph) == 32'($past(ph))) ||
       (32'(ph) == (32'($past(ph)) + 1) % SPB) ||
       (32'(ph) == (32'($past(ph)) + 2) % SPB)));

  p_auto_fine_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && locked) |-> !trk_fast);

  p_fast_realign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edge_i && trk_fast) |=> (32'(ph) == 1));

  p_lock_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (!$past(en) || bit_stb));

  p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!locked && !bit_stb));
endmodule

bind preamble_bit_sync pbs_chk #(.SPB(SPB)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .bit_stb(bit_stb),
  .locked(locked), .edge_i(edge_w), .trk_fast(trk_fast_w), .ph(ph_w)
);

// File: tb/sim_preamble_bit_sync.sv
module sim_preamble_bit_sync;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       din = 1'b0;
  logic       bit_out, bit_stb, locked;
  logic       cur = 1'b0;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  preamble_bit_sync u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .din(din),
    .bit_out(bit_out), .bit_stb(bit_stb), .locked(locked)
  );

  // mode, bit period, transitions with no lock yet, transitions by which lock holds
  localparam int TBL [7][4] = '{
    '{0, 16,  7, 11}, '{1, 16, 15, 28}, '{2, 16,  7, 11}, '{0, 15,  7, 11},
    '{0, 17,  7, 11}, '{1, 17, 15, 30}, '{3, 16, 15, 28}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; din = 1'b0; cur = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drive one bit for len cycles; report first strobe offset and strobe count
  task automatic drive_bit(input logic b, input int len, input bit chk_data,
                           output int first, output int nstb);
    din = b; first = -1; nstb = 0;
    for (int c = 1; c <= len; c++) begin
      @(negedge clk);
      if (bit_stb) begin
        nstb++;
        if (first < 0) first = c;
        if (chk_data) check(bit_out == b, "R2 data", int'(bit_out), int'(b));
      end
    end
  endtask

  task automatic preamble(input int n, input int len);
    int f, s;
    for (int i = 0; i < n; i++) begin
      cur = ~cur;
      drive_bit(cur, len, 1'b0, f, s);
    end
  endtask

  task automatic hold_bits(input int n, input int len);
    int f, s;
    for (int i = 0; i < n; i++) drive_bit(cur, len, 1'b0, f, s);
  endtask

  // Strobe delay after a late transition, relative to a well-timed one
  task automatic late_edge(output int d_norm, output int d_late);
    int f, s;
    cur = ~cur; drive_bit(cur, 16, 1'b0, d_norm, s);
    cur = ~cur; drive_bit(cur, 22, 1'b0, f, s);
    cur = ~cur; drive_bit(cur, 16, 1'b0, d_late, s);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int f, s, tot, dn, dl;
    string tag;
    #1;
    do_reset();
    // R1: reset state
    check(!locked && !bit_stb && !bit_out, "R1 reset outputs", int'({locked, bit_stb, bit_out}), 0);

    // Table walk: lock length per mode and bit period
    for (int r = 0; r < 7; r++) begin
      tag = (TBL[r][0] == 0) ? "R3" : (TBL[r][0] == 2) ? "R5" : "R4";
      do_reset();
      mode = 2'(TBL[r][0]); en = 1'b1;
      hold_bits(3, TBL[r][1]);
      for (int i = 1; i <= TBL[r][3]; i++) begin
        cur = ~cur;
        drive_bit(cur, TBL[r][1], 1'b0, f, s);
        if (i == TBL[r][2]) check(!locked, {tag, " early lock"}, int'(locked), 0);
      end
      check(locked, {tag, " lock reached"}, int'(locked), 1);
    end

    // R2: data recovery at mid-bit, one strobe per bit
    do_reset(); mode = 2'd0; en = 1'b1;
    hold_bits(2, 16); preamble(10, 16);
    check(locked, "R2 lock before data", int'(locked), 1);
    for (int i = 15; i >= 0; i--) begin
      cur = 1'((16'hB38E >> i) & 1);
      drive_bit(cur, 16, 1'b1, f, s);
      check(s == 1, "R2 strobes per bit", s, 1);
    end

    // R1: reset while locked
    rst_n = 1'b0;
    @(negedge clk);
    check(!locked && !bit_stb, "R1 reset mid-run", int'(locked), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: gap restarts the lock count
    do_reset(); mode = 2'd0; en = 1'b1;
    hold_bits(2, 16); preamble(5, 16); hold_bits(3, 16); preamble(7, 16);
    check(!locked, "R7 no lock after gap", int'(locked), 0);
    preamble(4, 16);
    check(locked, "R7 lock after full run", int'(locked), 1);

    // R8: idle timeout
    hold_bits(29, 16);
    check(locked, "R8 lock held 29 idle bits", int'(locked), 1);
    hold_bits(6, 16);
    check(!locked, "R8 lock lost after 35 idle bits", int'(locked), 0);

    // R9: enable low
    preamble(10, 16);
    check(locked, "R9 relock", int'(locked), 1);
    en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(!locked, "R9 lock cleared", int'(locked), 0);
    tot = 0;
    for (int i = 0; i < 12; i++) begin
      cur = ~cur; drive_bit(cur, 16, 1'b0, f, s); tot += s;
    end
    check(tot == 0 && !locked, "R9 no strobes", tot, 0);
    en = 1'b1;

    // R6: fast tracking realigns fully on a late edge
    do_reset(); mode = 2'd0; en = 1'b1;
    hold_bits(2, 16); preamble(10, 16);
    late_edge(dn, dl);
    check(dn > 0 && dl == dn, "R6 fast realign", dl, dn);

    // R5: automatic mode tracks in single-sample steps once locked
    do_reset(); mode = 2'd2; en = 1'b1;
    hold_bits(2, 16); preamble(10, 16);
    check(locked, "R5 auto locked", int'(locked), 1);
    late_edge(dn, dl);
    check(dn > 0 && dl == dn - 5, "R5 auto fine tracking", dl, dn - 5);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule